// File: doc/BRIEF.md
# Priority IO Port Crossbar

This block decides, for each pin of an eight-pin general-purpose port, which on-chip function drives the pin's direction and output value. Several peripherals can ask for the same pin: the clock-source selection, an SPI master, a shared serial port (flash programming or SPI slave), a debug port, a 2-wire bus, two PWM channels and analog inputs. Ownership is settled by seven fixed priority levels. Level 1 is the highest and level 7 the lowest. When no level claims a pin, the GPIO direction and output registers drive it.

In the other direction, the block sends each pin's input value to the functions that listen on it. A function that needs a pin as an input gets the pad value only while it owns that pin. Listeners that never claim a pin (GPIO readback, two external interrupts, a timer input and the UART receive line) see the pad whenever the pin is in digital input mode.

The block is purely combinational. It has no clock and no reset. Its outputs are meant to feed the pad ring and the peripherals directly.

Top module: `pio_xbar`

## Requirements
- R1: When more than one level requests a pin, the lowest-numbered level wins. The levels are, with their claims:
  - L1 (clock select): pins 0 and 1.
  - L2 (SPI master, `spim_en`): pin 2 as input, pins 3 and 4 as outputs.
  - L3 (serial port, `prog | spis_en`): pins 2, 4 and 5 as inputs, pin 3 as output.
  - L4 (debug, `dbg_en`): pins 0, 1 and 2 as inputs, pin 3 as output.
  - L5 (2-wire, `twi_en`): pins 3 and 4.
  - L6 (PWM): pin 4 with `pwm_en[0]`, pin 5 with `pwm_en[1]`.
  - L7 (analog): pins 0, 1, 2, 3, 4 and 6 with `ana_sel`.
- R2: When `lfclk_sel` is 3'b000, the following hold:
  - Pins 0 and 1 are reserved for the crystal: `pad_oe` is 0 and `pad_ana` is 1 on both.
  - `xtal_en` is 1.
  - GPIO and every lower level are ignored on these two pins.
- R3: The other clock codes behave as follows:
  - 3'b011 reserves pin 1 only, as an analog input.
  - 3'b100 reserves pin 0 as a digital input and sets `lfclk_dig` to `pad_in[0]`.
  - Any other code reserves no pin.
  - `lfclk_dig` is 0 for every code other than 3'b100.
- R4: On an unclaimed pin, `pad_oe` equals `gpio_oe[p]` and the output value equals `gpio_out[p]`.
- R5: On pin 5, when GPIO owns the pin, the output value is `gpio_out[5] & uart_txd`.
- R6: With `prog` low and the serial port owning pin 3, `pad_oe[3]` is 1 only while the slave chip select (pin 2, active low) reads 0.
- R7: The serial port is routed to flash or to slave depending on `prog`:
  - With `prog` high, the L3 pins serve flash programming. Pin 3 carries `flash_miso` and is always driven. The slave inputs are inactive.
  - With `prog` low, the flash inputs are inactive: `flash_csn`=1, `flash_mosi`=0, `flash_sck`=0.
- R8: A pin won by an analog claim behaves as follows:
  - `pad_oe` is 0 and `pad_ana` is 1.
  - All digital listeners of that pin read 0.
  - `ana_sel[5]` and `ana_sel[7]` have no effect.
- R9: The listeners read the pad only while their pin is in digital input mode (`pad_oe`=0 and `pad_ana`=0):
  - `gpio_in[p]` reads pin p.
  - `int_in[0]` reads pin 0 and `int_in[1]` reads pin 2.
  - `timer_in` reads pin 4.
  - `uart_rxd` reads pin 6.
  - Otherwise they read 0, except `uart_rxd`, which reads 1.
- R10: When the 2-wire bus owns pins 3 or 4, each pin is open drain:
  - `pad_oe` is the inverse of `scl_drv` (pin 3) or `sda_drv` (pin 4), and `pad_out` is 0.
  - `scl_in` and `sda_in` carry the pad value while the bus owns the pin, and 1 otherwise.
- R11: A claimed input function (SPI master MISO, flash or slave CSN/MOSI/SCK, debug TCK/TMS/TDI) gets `pad_in` of its pin only when its level wins that pin. Otherwise it gets its inactive value: 1 for chip selects, 0 for the rest.
- R12: Whenever `pad_oe[p]` is 0, `pad_out[p]` is 0. All outputs are a combinational function of the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lfclk_sel | input | 3 | Low-frequency clock source select |
| spim_en | input | 1 | SPI master enable |
| prog | input | 1 | Flash programming mode |
| spis_en | input | 1 | SPI slave enable |
| dbg_en | input | 1 | Debug port enable |
| twi_en | input | 1 | 2-wire bus enable |
| pwm_en | input | 2 | PWM channel enables |
| ana_sel | input | 8 | Analog input select per pin |
| gpio_oe | input | 8 | GPIO direction (1 = output) |
| gpio_out | input | 8 | GPIO output values |
| uart_txd | input | 1 | UART transmit data (idle high) |
| spim_mosi | input | 1 | SPI master data out |
| spim_sck | input | 1 | SPI master clock out |
| flash_miso | input | 1 | Flash-programming data out |
| slv_miso | input | 1 | SPI slave data out |
| dbg_tdo | input | 1 | Debug data out |
| scl_drv | input | 1 | 2-wire clock level (0 pulls low) |
| sda_drv | input | 1 | 2-wire data level (0 pulls low) |
| pwm_val | input | 2 | PWM channel outputs |
| pad_in | input | 8 | Pad input values |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_ana | output | 8 | Pad analog connection enables |
| xtal_en | output | 1 | Crystal oscillator enable |
| lfclk_dig | output | 1 | Digital low-frequency clock input |
| gpio_in | output | 8 | GPIO input readback |
| int_in | output | 2 | External interrupt inputs |
| timer_in | output | 1 | Timer count input |
| uart_rxd | output | 1 | UART receive data |
| spim_miso | output | 1 | SPI master data in |
| flash_csn | output | 1 | Flash-programming chip select |
| flash_mosi | output | 1 | Flash-programming data in |
| flash_sck | output | 1 | Flash-programming clock |
| slv_csn | output | 1 | SPI slave chip select |
| slv_mosi | output | 1 | SPI slave data in |
| slv_sck | output | 1 | SPI slave clock |
| dbg_tck | output | 1 | Debug clock |
| dbg_tms | output | 1 | Debug mode select |
| dbg_tdi | output | 1 | Debug data in |
| scl_in | output | 1 | 2-wire clock in |
| sda_in | output | 1 | 2-wire data in |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes inputs right after a falling-edge check. It then lets a whole clock period pass and samples all outputs at the next falling edge, well clear of the rising edge. The reference model recomputes pin ownership from per-level offers, and every output is compared against it on each of those samples. Directed cases cover each conflict and each clock code, and a long random run covers the remaining combinations.

// File: rtl/pio_xbar_pkg.sv
// Package: shared constants and the per-level claim record of the port crossbar.
// Assumes an eight-pin port and seven priority levels, index 0 being the highest.
package pio_xbar_pkg;
    localparam int NUM_PINS = 8;
    localparam int NUM_LEV  = 7;
    localparam int PWM_CH   = 2;
    localparam int INT_CH   = 2;
    localparam int LF_W     = 3;

    // Level indices, lowest index wins
    localparam int L_CLK  = 0;
    localparam int L_SPIM = 1;
    localparam int L_SER  = 2;
    localparam int L_DBG  = 3;
    localparam int L_TWI  = 4;
    localparam int L_PWM  = 5;
    localparam int L_ANA  = 6;

    localparam logic [LF_W-1:0] LF_XTAL = 3'b000;
    localparam logic [LF_W-1:0] LF_ACLK = 3'b011;
    localparam logic [LF_W-1:0] LF_DCLK = 3'b100;

    localparam logic [NUM_PINS-1:0] ANA_MASK = 8'b0101_1111;
    localparam int TXD_PIN = 5;

    typedef struct packed {
        logic req;
        logic oe;
        logic out;
        logic ana;
    } claim_t;
endpackage

// File: rtl/pio_prio_pick.sv
// Module: fixed-priority one-hot picker over the claim levels of one pin.
// Assumes bit 0 is the highest priority; none is high when no bit requests.
module pio_prio_pick #(
    parameter int NLEV = 7
) (
    input  logic [NLEV-1:0] req,
    output logic [NLEV-1:0] grant,
    output logic            none
);
    // Purpose: grant the lowest-indexed requesting level.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NLEV; i++) begin
            if (!found && req[i]) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        none = !found;
    end
endmodule

// File: rtl/pio_pin_mux.sv
// Module: resolves one pin's pad controls from its level claims, falling
// back to the GPIO register bits when no level requests the pin.
// Assumes analog claims carry oe=0; forces the output value to 0 when undriven.
module pio_pin_mux
    import pio_xbar_pkg::*;
#(
    parameter int NLEV = NUM_LEV
) (
    input  claim_t [NLEV-1:0] cl,
    input  logic              gpio_oe,
    input  logic              gpio_val,
    output logic              pad_oe,
    output logic              pad_out,
    output logic              pad_ana
);
    logic [NLEV-1:0] req_v, oe_v, out_v, ana_v, grant;
    logic            none;
    logic            val;

    for (genvar l = 0; l < NLEV; l++) begin : g_unpack
        assign req_v[l] = cl[l].req;
        assign oe_v[l]  = cl[l].oe;
        assign out_v[l] = cl[l].out;
        assign ana_v[l] = cl[l].ana;
    end

    pio_prio_pick #(.NLEV(NLEV)) u_pick (
        .req   (req_v),
        .grant (grant),
        .none  (none)
    );

    // Purpose: select winner's controls or GPIO defaults for the pad.
    always_comb begin
        if (none) begin
            pad_oe  = gpio_oe;
            val     = gpio_val;
            pad_ana = 1'b0;
        end else begin
            pad_oe  = |(grant & oe_v);
            val     = |(grant & out_v);
            pad_ana = |(grant & ana_v);
        end
        pad_out = pad_oe & val;
    end
endmodule

// File: rtl/pio_xbar.sv
// Module: top of the priority port crossbar. Builds each pin's level claims,
// resolves them per pin, and routes pad inputs back to the peripherals.
// Assumes a purely combinational context; no clock or reset is used.
module pio_xbar
    import pio_xbar_pkg::*;
(
    input  logic [LF_W-1:0]     lfclk_sel,
    input  logic                spim_en,
    input  logic                prog,
    input  logic                spis_en,
    input  logic                dbg_en,
    input  logic                twi_en,
    input  logic [PWM_CH-1:0]   pwm_en,
    input  logic [NUM_PINS-1:0] ana_sel,
    input  logic [NUM_PINS-1:0] gpio_oe,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic                uart_txd,
    input  logic                spim_mosi,
    input  logic                spim_sck,
    input  logic                flash_miso,
    input  logic                slv_miso,
    input  logic                dbg_tdo,
    input  logic                scl_drv,
    input  logic                sda_drv,
    input  logic [PWM_CH-1:0]   pwm_val,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_ana,
    output logic                xtal_en,
    output logic                lfclk_dig,
    output logic [NUM_PINS-1:0] gpio_in,
    output logic [INT_CH-1:0]   int_in,
    output logic                timer_in,
    output logic                uart_rxd,
    output logic                spim_miso,
    output logic                flash_csn,
    output logic                flash_mosi,
    output logic                flash_sck,
    output logic                slv_csn,
    output logic                slv_mosi,
    output logic                slv_sck,
    output logic                dbg_tck,
    output logic                dbg_tms,
    output logic                dbg_tdi,
    output logic                scl_in,
    output logic                sda_in
);
    claim_t [NUM_PINS-1:0][NUM_LEV-1:0] cl;
    logic                               ser_on;
    logic                               slv_sel_low;
    logic [NUM_PINS-1:0]                in_mode;

    // Purpose: true when level l is the highest requester in claim set c.
    function automatic logic wins(input claim_t [NUM_LEV-1:0] c, input int l);
        logic higher;
        higher = 1'b0;
        for (int i = 0; i < NUM_LEV; i++)
            if (i < l && c[i].req) higher = 1'b1;
        return c[l].req && !higher;
    endfunction

    assign ser_on      = prog | spis_en;
    // Pin 2 belongs to the slave only when the SPI master does not hold it.
    assign slv_sel_low = spis_en & ~prog & ~spim_en & ~pad_in[2];

    // Purpose: build every pin's request record for each priority level.
    always_comb begin
        cl = '0;
        cl[0][L_CLK].req  = (lfclk_sel == LF_XTAL) || (lfclk_sel == LF_DCLK);
        cl[0][L_CLK].ana  = (lfclk_sel == LF_XTAL);
        cl[1][L_CLK].req  = (lfclk_sel == LF_XTAL) || (lfclk_sel == LF_ACLK);
        cl[1][L_CLK].ana  = 1'b1;

        cl[2][L_SPIM].req = spim_en;
        cl[3][L_SPIM].req = spim_en;
        cl[3][L_SPIM].oe  = 1'b1;
        cl[3][L_SPIM].out = spim_mosi;
        cl[4][L_SPIM].req = spim_en;
        cl[4][L_SPIM].oe  = 1'b1;
        cl[4][L_SPIM].out = spim_sck;

        cl[2][L_SER].req  = ser_on;
        cl[3][L_SER].req  = ser_on;
        cl[3][L_SER].oe   = prog | slv_sel_low;
        cl[3][L_SER].out  = prog ? flash_miso : slv_miso;
        cl[4][L_SER].req  = ser_on;
        cl[5][L_SER].req  = ser_on;

        for (int p = 0; p < 3; p++) cl[p][L_DBG].req = dbg_en;
        cl[3][L_DBG].req  = dbg_en;
        cl[3][L_DBG].oe   = 1'b1;
        cl[3][L_DBG].out  = dbg_tdo;

        cl[3][L_TWI].req  = twi_en;
        cl[3][L_TWI].oe   = ~scl_drv;
        cl[4][L_TWI].req  = twi_en;
        cl[4][L_TWI].oe   = ~sda_drv;

        cl[4][L_PWM].req  = pwm_en[0];
        cl[4][L_PWM].oe   = 1'b1;
        cl[4][L_PWM].out  = pwm_val[0];
        cl[5][L_PWM].req  = pwm_en[1];
        cl[5][L_PWM].oe   = 1'b1;
        cl[5][L_PWM].out  = pwm_val[1];

        for (int p = 0; p < NUM_PINS; p++) begin
            cl[p][L_ANA].req = ana_sel[p] & ANA_MASK[p];
            cl[p][L_ANA].ana = 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic gval;
        if (p == TXD_PIN) begin : g_txd
            assign gval = gpio_out[p] & uart_txd;
        end else begin : g_plain
            assign gval = gpio_out[p];
        end
        pio_pin_mux #(.NLEV(NUM_LEV)) u_mux (
            .cl       (cl[p]),
            .gpio_oe  (gpio_oe[p]),
            .gpio_val (gval),
            .pad_oe   (pad_oe[p]),
            .pad_out  (pad_out[p]),
            .pad_ana  (pad_ana[p])
        );
        assign in_mode[p] = ~pad_oe[p] & ~pad_ana[p];
    end

    // Purpose: route pad values to listeners and to winning input functions.
    always_comb begin
        gpio_in    = pad_in & in_mode;
        int_in[0]  = gpio_in[0];
        int_in[1]  = gpio_in[2];
        timer_in   = gpio_in[4];
        uart_rxd   = in_mode[6] ? pad_in[6] : 1'b1;
        xtal_en    = (lfclk_sel == LF_XTAL);
        lfclk_dig  = (lfclk_sel == LF_DCLK) & pad_in[0];
        spim_miso  = wins(cl[2], L_SPIM) & pad_in[2];
        flash_csn  = (prog && wins(cl[2], L_SER)) ? pad_in[2] : 1'b1;
        flash_mosi = prog & wins(cl[4], L_SER) & pad_in[4];
        flash_sck  = prog & wins(cl[5], L_SER) & pad_in[5];
        slv_csn    = (!prog && wins(cl[2], L_SER)) ? pad_in[2] : 1'b1;
        slv_mosi   = ~prog & wins(cl[4], L_SER) & pad_in[4];
        slv_sck    = ~prog & wins(cl[5], L_SER) & pad_in[5];
        dbg_tck    = wins(cl[0], L_DBG) & pad_in[0];
        dbg_tms    = wins(cl[1], L_DBG) & pad_in[1];
        dbg_tdi    = wins(cl[2], L_DBG) & pad_in[2];
        scl_in     = wins(cl[3], L_TWI) ? pad_in[3] : 1'b1;
        sda_in     = wins(cl[4], L_TWI) ? pad_in[4] : 1'b1;
    end
endmodule

// File: rtl/pio_xbar_chk.sv
// Module: property checker for the port crossbar, attached by bind.
// Assumes purely combinational behaviour, so all checks are immediate.
module pio_xbar_chk
    import pio_xbar_pkg::*;
(
    input logic [LF_W-1:0]     lfclk_sel,
    input logic                spim_en,
    input logic                prog,
    input logic                spis_en,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_ana,
    input logic [NUM_PINS-1:0] gpio_in,
    input logic                lfclk_dig,
    input logic                flash_csn,
    input logic                flash_mosi,
    input logic                flash_sck,
    input logic                slv_csn
);
    // Purpose: evaluate crossbar invariants whenever any observed signal moves.
    always_comb begin
        AST_XTAL_PINS_QUIET: assert (lfclk_sel != LF_XTAL || (pad_oe[1:0] == 2'b00 && pad_ana[1:0] == 2'b11))
            else $error("crystal pins driven"); // R2
        AST_LFDIG_IDLE: assert (lfclk_sel == LF_DCLK || !lfclk_dig)
            else $error("digital clock leaks"); // R3
        AST_SMISO_GATE: assert (!(!prog && spis_en && !spim_en && slv_csn) || !pad_oe[3])
            else $error("slave MISO driven while deselected"); // R6
        AST_FLASH_IDLE: assert (prog || (flash_csn && !flash_mosi && !flash_sck))
            else $error("flash inputs active without prog"); // R7
        AST_ANALOG_NO_DRIVE: assert ((pad_oe & pad_ana) == '0)
            else $error("analog pin driven"); // R8
        AST_LISTEN_INPUT_ONLY: assert ((gpio_in & (pad_oe | pad_ana)) == '0)
            else $error("listener sees non-input pin"); // R9
        AST_QUIET_OUT: assert ((pad_out & ~pad_oe) == '0)
            else $error("value on undriven pin"); // R12
    end
endmodule

bind pio_xbar pio_xbar_chk u_chk (.*);

// File: tb/tb_pio_xbar.sv
module tb_pio_xbar;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] lfclk_sel;
    logic spim_en, prog, spis_en, dbg_en, twi_en;
    logic [1:0] pwm_en, pwm_val;
    logic [7:0] ana_sel, gpio_oe, gpio_out, pad_in;
    logic uart_txd, spim_mosi, spim_sck, flash_miso, slv_miso, dbg_tdo, scl_drv, sda_drv;
    logic [7:0] pad_oe, pad_out, pad_ana, gpio_in;
    logic [1:0] int_in;
    logic xtal_en, lfclk_dig, timer_in, uart_rxd, spim_miso;
    logic flash_csn, flash_mosi, flash_sck, slv_csn, slv_mosi, slv_sck;
    logic dbg_tck, dbg_tms, dbg_tdi, scl_in, sda_in;

    pio_xbar dut (.*);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int lvl [8];
    logic [7:0] e_oe, e_out, e_ana, e_gin;
    logic e_slv_csn;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void offer(int p, int l);
        if (l < lvl[p]) lvl[p] = l;
    endfunction

    // Reference: offers per function, lowest level kept; 8 means GPIO.
    task automatic model();
        for (int p = 0; p < 8; p++) lvl[p] = 8;
        for (int p = 0; p < 8; p++)
            if (ana_sel[p] && p != 5 && p != 7) offer(p, 7);
        if (pwm_en[0]) offer(4, 6);
        if (pwm_en[1]) offer(5, 6);
        if (twi_en) begin offer(3, 5); offer(4, 5); end
        if (dbg_en) for (int p = 0; p < 4; p++) offer(p, 4);
        if (prog || spis_en) for (int p = 2; p < 6; p++) offer(p, 3);
        if (spim_en) for (int p = 2; p < 5; p++) offer(p, 2);
        if (lfclk_sel == 3'b000) begin offer(0, 1); offer(1, 1); end
        if (lfclk_sel == 3'b011) offer(1, 1);
        if (lfclk_sel == 3'b100) offer(0, 1);
        e_slv_csn = (!prog && lvl[2] == 3) ? pad_in[2] : 1'b1;
        for (int p = 0; p < 8; p++) begin
            logic o, v, a;
            o = 0; v = 0; a = 0;
            case (lvl[p])
                1: a = (lfclk_sel == 3'b000) || p == 1;
                2: if (p == 3) begin o = 1; v = spim_mosi; end
                   else if (p == 4) begin o = 1; v = spim_sck; end
                3: if (p == 3) begin o = prog ? 1'b1 : !e_slv_csn; v = prog ? flash_miso : slv_miso; end
                4: if (p == 3) begin o = 1; v = dbg_tdo; end
                5: o = (p == 3) ? !scl_drv : !sda_drv;
                6: begin o = 1; v = (p == 4) ? pwm_val[0] : pwm_val[1]; end
                7: a = 1;
                default: begin o = gpio_oe[p]; v = gpio_out[p] & ((p == 5) ? uart_txd : 1'b1); end
            endcase
            e_oe[p] = o; e_out[p] = o & v; e_ana[p] = a;
            e_gin[p] = (!o && !a) ? pad_in[p] : 1'b0;
        end
    endtask

    task automatic compare(string tag);
        model();
        chk(tag, "pad_oe", pad_oe, e_oe);
        chk(tag, "pad_out", pad_out, e_out);
        chk(tag, "pad_ana", pad_ana, e_ana);
        chk(tag, "gpio_in", gpio_in, e_gin);
        chk(tag, "int_in", int_in, {e_gin[2], e_gin[0]});
        chk(tag, "timer_in", timer_in, e_gin[4]);
        chk(tag, "uart_rxd", uart_rxd, (!e_oe[6] && !e_ana[6]) ? pad_in[6] : 1'b1);
        chk(tag, "xtal_en", xtal_en, lfclk_sel == 3'b000);
        chk(tag, "lfclk_dig", lfclk_dig, (lfclk_sel == 3'b100) ? pad_in[0] : 1'b0);
        chk(tag, "spim_miso", spim_miso, lvl[2] == 2 ? pad_in[2] : 1'b0);
        chk(tag, "flash_csn", flash_csn, (prog && lvl[2] == 3) ? pad_in[2] : 1'b1);
        chk(tag, "flash_mosi", flash_mosi, (prog && lvl[4] == 3) ? pad_in[4] : 1'b0);
        chk(tag, "flash_sck", flash_sck, (prog && lvl[5] == 3) ? pad_in[5] : 1'b0);
        chk(tag, "slv_csn", slv_csn, e_slv_csn);
        chk(tag, "slv_mosi", slv_mosi, (!prog && lvl[4] == 3) ? pad_in[4] : 1'b0);
        chk(tag, "slv_sck", slv_sck, (!prog && lvl[5] == 3) ? pad_in[5] : 1'b0);
        chk(tag, "dbg_tck", dbg_tck, lvl[0] == 4 ? pad_in[0] : 1'b0);
        chk(tag, "dbg_tms", dbg_tms, lvl[1] == 4 ? pad_in[1] : 1'b0);
        chk(tag, "dbg_tdi", dbg_tdi, lvl[2] == 4 ? pad_in[2] : 1'b0);
        chk(tag, "scl_in", scl_in, lvl[3] == 5 ? pad_in[3] : 1'b1);
        chk(tag, "sda_in", sda_in, lvl[4] == 5 ? pad_in[4] : 1'b1);
    endtask

    // Inputs change right after a falling-edge sample; next sample one period later.
    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        lfclk_sel = 3'b001; spim_en = 0; prog = 0; spis_en = 0; dbg_en = 0; twi_en = 0;
        pwm_en = 0; pwm_val = 0; ana_sel = 0; gpio_oe = 0; gpio_out = 0; pad_in = 0;
        uart_txd = 1; spim_mosi = 0; spim_sck = 0; flash_miso = 0; slv_miso = 0;
        dbg_tdo = 0; scl_drv = 1; sda_drv = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        lfclk_sel = 3'b000;
        settle();
        // Start-up state with all enables low: crystal code reserves pins 0/1
        compare("R2");

        gpio_oe = 8'hFF; gpio_out = 8'hFF; dbg_en = 1; ana_sel = 8'h03;
        settle();
        chk("R2", "crystal pad_oe[1:0]", pad_oe[1:0], 2'b00);
        chk("R2", "crystal pad_ana[1:0]", pad_ana[1:0], 2'b11);
        chk("R2", "dbg_tck blocked", dbg_tck, 1'b0);
        compare("R2");

        idle(); lfclk_sel = 3'b011; gpio_oe = 8'h03; gpio_out = 8'h03;
        settle();
        chk("R3", "aclk pad_oe[1:0]", pad_oe[1:0], 2'b01);
        compare("R3");
        idle(); lfclk_sel = 3'b100; gpio_oe = 8'h01; pad_in = 8'h01;
        settle();
        chk("R3", "dclk lfclk_dig", lfclk_dig, 1'b1);
        chk("R3", "dclk pad_oe[0]", pad_oe[0], 1'b0);
        compare("R3");
        for (int c = 0; c < 8; c++) begin
            idle(); lfclk_sel = c[2:0]; gpio_oe = 8'h03; gpio_out = 8'h02; pad_in = 8'hFF;
            settle();
            compare("R3");
        end

        idle(); gpio_oe = 8'hA5; gpio_out = 8'h0F;
        settle();
        chk("R4", "gpio pad_oe", pad_oe, 8'hA5);
        chk("R4", "gpio pad_out", pad_out, 8'h05);
        compare("R4");

        idle(); gpio_oe = 8'h20; gpio_out = 8'h20; uart_txd = 0;
        settle();
        chk("R5", "txd low pulls pin5", pad_out[5], 1'b0);
        uart_txd = 1;
        settle();
        chk("R5", "txd idle passes gpio", pad_out[5], 1'b1);
        compare("R5");

        idle(); spis_en = 1; slv_miso = 1; pad_in = 8'h04;
        settle();
        chk("R6", "deselected miso oe", pad_oe[3], 1'b0);
        compare("R6");
        pad_in = 8'h00;
        settle();
        chk("R6", "selected miso oe", pad_oe[3], 1'b1);
        chk("R6", "selected miso val", pad_out[3], 1'b1);
        compare("R6");

        idle(); spis_en = 1; prog = 1; flash_miso = 1; pad_in = 8'h34;
        settle();
        chk("R7", "flash miso oe", pad_oe[3], 1'b1);
        chk("R7", "slave csn inactive", slv_csn, 1'b1);
        chk("R7", "flash sck", flash_sck, 1'b1);
        compare("R7");
        prog = 0;
        settle();
        chk("R7", "flash csn idle", flash_csn, 1'b1);
        chk("R7", "flash mosi idle", flash_mosi, 1'b0);
        compare("R7");

        idle(); ana_sel = 8'hFF; gpio_oe = 8'hA0; gpio_out = 8'hFF; pad_in = 8'hFF;
        settle();
        chk("R8", "analog pad_ana", pad_ana, 8'h5F);
        chk("R8", "analog pad_oe", pad_oe, 8'hA0);
        chk("R8", "analog gpio_in", gpio_in, 8'h00);
        compare("R8");

        idle(); pad_in = 8'h55; gpio_oe = 8'h10;
        settle();
        chk("R9", "int_in shared", int_in, 2'b11);
        chk("R9", "timer on output pin", timer_in, 1'b0);
        gpio_oe = 8'h40;
        settle();
        chk("R9", "rxd on output pin", uart_rxd, 1'b1);
        compare("R9");

        idle(); twi_en = 1; scl_drv = 0; sda_drv = 1; pad_in = 8'h10;
        settle();
        chk("R10", "scl pulls low", {pad_oe[3], pad_out[3]}, 2'b10);
        chk("R10", "sda released", pad_oe[4], 1'b0);
        chk("R10", "sda_in", sda_in, 1'b1);
        compare("R10");

        idle(); spim_en = 1; dbg_en = 1; twi_en = 1; pwm_en = 2'b11; spim_mosi = 1; pad_in = 8'h07;
        settle();
        chk("R1", "spim wins pin3", pad_out[3], 1'b1);
        chk("R11", "spim miso routed", spim_miso, 1'b1);
        chk("R11", "dbg_tdi blocked", dbg_tdi, 1'b0);
        chk("R11", "dbg_tck routed", dbg_tck, 1'b1);
        compare("R1");
        spim_en = 0;
        settle();
        chk("R11", "dbg_tdi routed", dbg_tdi, 1'b1);
        compare("R11");

        // Broad sweep against the reference model, one comparison per clock
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r0, r1;
            r0 = $urandom; r1 = $urandom;
            lfclk_sel = r0[2:0]; spim_en = r0[3] & r0[4]; prog = r0[5] & r0[6];
            spis_en = r0[7]; dbg_en = r0[8]; twi_en = r0[9]; pwm_en = r0[11:10];
            ana_sel = r0[19:12]; gpio_oe = r0[27:20]; uart_txd = r0[28];
            spim_mosi = r0[29]; spim_sck = r0[30]; flash_miso = r0[31];
            gpio_out = r1[7:0]; pad_in = r1[15:8]; slv_miso = r1[16]; dbg_tdo = r1[17];
            scl_drv = r1[18]; sda_drv = r1[19]; pwm_val = r1[21:20];
            settle();
            compare("R12");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule